// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupting devices and a processor core. Each device owns one level-sensitive request line with a fixed priority that is set by a parameter. The controller compares the best outstanding request with the level the core is running at, and raises `irq` when that request may preempt the code now running. When the core answers with a one-cycle `cpu_ready` strobe, the controller acknowledges the winner. It presents the winner's small vector number and the handler address derived from it. It saves the interrupted program counter and running level on an internal stack, and then raises the running level to the winner's priority.

A one-cycle `ret` strobe marks the end of a handler. The controller pops the saved frame and hands the saved program counter back to the core. It drops the running level to the saved value. A request that was held back because its priority was too low is therefore signalled in the same cycle as the restored frame, so the core can take it before it resumes the interrupted code. A separate nonmaskable input is taken on its rising edge and overrides every level, including the level of another nonmaskable handler. Level 0 is ordinary program code.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq` is a registered output. It is high in the cycle after an edge exactly when, after that edge, a nonmaskable event is latched or some asserted `dev_req` line has a priority strictly above `run_level`. The exception is the edge that starts a return, after which `irq` is low.
- R2: An acknowledge happens only at an edge where `cpu_ready` is high and a winner exists. `ack` then goes high for one cycle and `vec` shows the winner: device i gives vector i+1 and the nonmaskable source gives vector 0. A `cpu_ready` with no winner has no effect.
- R3: `handler_addr` equals 4 times `vec`, because each table entry is 4 bytes.
- R4: Every acknowledge pushes `pc_in` and the current `run_level`. A later return gives that `pc_in` back on `ret_pc`, on a last-in first-out basis.
- R5: A request whose priority is not above `run_level` is neither signalled nor acknowledged. It stays waiting until the level drops below it.
- R6: A request of strictly higher priority is acknowledged while another handler runs, and `run_level` rises to its priority.
- R7: A `ret` at edge k makes `ret_valid` high for one cycle after edge k+1, with the saved `ret_pc` and the saved `run_level`. `irq` reflects waiting requests against the restored level in that same cycle.
- R8: A rising edge on `nmi` is latched and beats all device requests at every running level. It is acknowledged with vector 0 and runs at the maximum level, 7.
- R9: Among waiting requests of equal priority, the lowest device index wins.
- R10: The stack holds 9 frames. An acknowledge while 9 frames are stored drops the frame and sets `stack_err`, which then stays high until reset.
- R11: A `ret` is ignored when the stack is empty or while a return is in progress. When `ret` and `cpu_ready` arrive together, the return is performed and the acknowledge is not.
- R12: Requests are level-sensitive. A line that is still high after its handler returns is taken again, and a line dropped before it is acknowledged is forgotten.
- R13: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_SRC | Level-sensitive device request lines |
| nmi | input | 1 | Nonmaskable event input, taken on its rising edge |
| cpu_ready | input | 1 | Core is ready to take an interrupt (one-cycle strobe) |
| ret | input | 1 | Return from handler (one-cycle strobe) |
| pc_in | input | PC_W | Program counter to save on acknowledge |
| irq | output | 1 | Interrupt request to the core |
| ack | output | 1 | One-cycle acknowledge pulse |
| vec | output | VEC_W | Vector of the last acknowledged source |
| handler_addr | output | VEC_W+2 | Handler table address, 4 times `vec` |
| run_level | output | PRIO_W | Priority level the core is running at |
| ret_valid | output | 1 | One-cycle pulse while the restored frame is presented |
| ret_pc | output | PC_W | Program counter restored by the last return |
| stack_err | output | 1 | Sticky flag set when a frame is dropped on overflow |

## Verification
The assertions assume that `cpu_ready` and `ret` are single-cycle strobes from a core that behaves well. A return is issued only by a handler that was entered, except in the deliberate empty-stack probes, and frames are popped in the order they were pushed. The stimulus keeps to this by driving every strobe for exactly one cycle, at the falling clock edge. It lowers each device line before the return of that device's handler, except in the cases that test re-entry on a level request. Nonmaskable events are given as short pulses, so that each one forms a separate rising edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PC_W   = 16;
  localparam int PRIO_W = 3;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [PRIO_W-1:0] lvl;
  } frame_t;
endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N  = 4,
  parameter int PW = 3,
  parameter int VW = 4,
  parameter logic [N*PW-1:0] PRIOS = '0
) (
  input  logic [N-1:0]  req,
  input  logic          nmi_pend,
  input  logic [PW-1:0] thresh,
  output logic          valid,
  output logic [VW-1:0] win_vec,
  output logic [PW-1:0] win_prio
);
  logic [PW-1:0] p;

  always_comb begin
    valid    = 1'b0;
    win_vec  = '0;
    win_prio = '0;
    p        = '0;
    for (int i = 0; i < N; i++) begin
      p = PRIOS[i*PW +: PW];
      // strict compare keeps the lower index on a tie
      if (req[i] && (p > thresh) && (!valid || (p > win_prio))) begin
        valid    = 1'b1;
        win_prio = p;
        win_vec  = VW'(i + 1);
      end
    end
    if (nmi_pend) begin
      valid    = 1'b1;
      win_prio = '1;
      win_vec  = '0;
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack #(
  parameter int DEPTH = 9,
  parameter int W     = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         overflow
);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic           full;

  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);

  always_ff @(posedge clk) begin
    if (push && !full) mem[sp] <= push_data;
    if (pop && !empty) pop_data <= mem[sp - SPW'(1)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp       <= '0;
      overflow <= 1'b0;
    end else begin
      if (push && !full)      sp <= sp + SPW'(1);
      else if (pop && !empty) sp <= sp - SPW'(1);
      if (push && full) overflow <= 1'b1;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    sp <= SPW'(DEPTH));
  p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  p_one_op_r4: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int VEC_W   = 4,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {3'd4, 3'd5, 3'd4, 3'd2}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  dev_req,
  input  logic                nmi,
  input  logic                cpu_ready,
  input  logic                ret,
  input  logic [PC_W-1:0]     pc_in,
  output logic                irq,
  output logic                ack,
  output logic [VEC_W-1:0]    vec,
  output logic [VEC_W+1:0]    handler_addr,
  output logic [PRIO_W-1:0]   run_level,
  output logic                ret_valid,
  output logic [PC_W-1:0]     ret_pc,
  output logic                stack_err
);
  localparam int DEPTH   = (1 << PRIO_W) + 1;
  localparam int FRAME_W = PC_W + PRIO_W;

  logic               pop_q, nmi_q, nmi_pend;
  logic               a_valid, n_valid;
  logic [VEC_W-1:0]   a_vec, n_vec;
  logic [PRIO_W-1:0]  a_prio, n_prio, nxt_lvl;
  logic               do_pop, acc, nmi_rise, npend_nxt, st_empty;
  frame_t             push_f, pop_f;
  logic [FRAME_W-1:0] pop_raw;

  // arbitration against the level now running: decides acceptance
  prio_irq_arb #(.N(NUM_SRC), .PW(PRIO_W), .VW(VEC_W), .PRIOS(SRC_PRIO)) u_arb_now (
    .req(dev_req), .nmi_pend(nmi_pend), .thresh(run_level),
    .valid(a_valid), .win_vec(a_vec), .win_prio(a_prio));

  // arbitration against the level after this edge: drives irq
  prio_irq_arb #(.N(NUM_SRC), .PW(PRIO_W), .VW(VEC_W), .PRIOS(SRC_PRIO)) u_arb_next (
    .req(dev_req), .nmi_pend(npend_nxt), .thresh(nxt_lvl),
    .valid(n_valid), .win_vec(n_vec), .win_prio(n_prio));

  assign do_pop    = ret && !pop_q && !st_empty;
  assign acc       = cpu_ready && !pop_q && !do_pop && a_valid;
  assign nmi_rise  = nmi && !nmi_q;
  assign npend_nxt = (nmi_pend && !(acc && (a_vec == '0))) || nmi_rise;
  assign pop_f     = pop_raw;
  assign push_f    = '{pc: pc_in, lvl: run_level};

  always_comb begin
    if (pop_q)    nxt_lvl = pop_f.lvl;
    else if (acc) nxt_lvl = a_prio;
    else          nxt_lvl = run_level;
  end

  prio_irq_stack #(.DEPTH(DEPTH), .W(FRAME_W)) u_stack (
    .clk(clk), .rst(rst), .push(acc), .push_data(push_f),
    .pop(do_pop), .pop_data(pop_raw), .empty(st_empty), .overflow(stack_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq          <= 1'b0;
      ack          <= 1'b0;
      vec          <= '0;
      handler_addr <= '0;
      run_level    <= '0;
      ret_valid    <= 1'b0;
      ret_pc       <= '0;
      pop_q        <= 1'b0;
      nmi_q        <= 1'b0;
      nmi_pend     <= 1'b0;
    end else begin
      irq       <= n_valid && !do_pop;
      ack       <= acc;
      run_level <= nxt_lvl;
      ret_valid <= pop_q;
      pop_q     <= do_pop;
      nmi_q     <= nmi;
      nmi_pend  <= npend_nxt;
      if (acc) begin
        vec          <= a_vec;
        handler_addr <= {a_vec, 2'b00};
      end
      if (pop_q) ret_pc <= pop_f.pc;
    end
  end

  always_comb begin
    if (!rst && a_valid && (a_vec != '0)) begin
      a_masked_r5: assert (a_prio > run_level);
    end
    if (!rst && n_valid && (n_vec != '0)) begin
      a_irq_above_r1: assert (n_prio > nxt_lvl);
    end
  end

  p_ack_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(cpu_ready));
  p_ack_raises_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && (vec != '0)) |-> (run_level > $past(run_level)));
  p_nmi_top_level_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && (vec == '0)) |-> (run_level == '1));
  p_no_ack_on_restore_r11: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> !ack);
  p_ret_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> !ret_valid);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req = '0;
  logic        nmi = 1'b0, rdy = 1'b0, ret = 1'b0;
  logic [15:0] pc = '0;
  logic        irq, ack, ret_valid, stack_err;
  logic [3:0]  vec;
  logic [5:0]  haddr;
  logic [2:0]  run;
  logic [15:0] ret_pc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .dev_req(req), .nmi(nmi), .cpu_ready(rdy), .ret(ret),
    .pc_in(pc), .irq(irq), .ack(ack), .vec(vec), .handler_addr(haddr),
    .run_level(run), .ret_valid(ret_valid), .ret_pc(ret_pc), .stack_err(stack_err));

  // behavioural reference model
  int PR[4] = '{2, 4, 5, 4};
  int m_run, m_vec, m_haddr, m_rpc, m_rd_pc, m_rd_pr;
  bit m_irq, m_ack, m_rv, m_err, m_popq, m_nmiq, m_npend;
  int st_pc[$], st_pr[$];

  function automatic void winner(input int th, input logic [3:0] r, input bit np,
                                 output bit v, output int wv, output int wp);
    v = 0; wv = 0; wp = 0;
    if (np) begin v = 1; wv = 0; wp = 7; return; end
    for (int i = 0; i < 4; i++)
      if (r[i] && PR[i] > th && (!v || PR[i] > wp)) begin v = 1; wv = i + 1; wp = PR[i]; end
  endfunction

  always @(posedge clk) begin
    bit rise, dp, acc, av, nv, npn;
    int avec, apr, nvec, npr, nxt;
    if (rst) begin
      m_run = 0; m_vec = 0; m_haddr = 0; m_rpc = 0; m_irq = 0; m_ack = 0;
      m_rv = 0; m_err = 0; m_popq = 0; m_nmiq = 0; m_npend = 0;
      st_pc.delete(); st_pr.delete();
    end else begin
      rise = nmi && !m_nmiq;
      dp   = ret && !m_popq && (st_pc.size() > 0);
      winner(m_run, req, m_npend, av, avec, apr);
      acc  = rdy && !m_popq && !dp && av;
      npn  = (m_npend && !(acc && avec == 0)) || rise;
      nxt  = m_popq ? m_rd_pr : (acc ? apr : m_run);
      m_rv = m_popq;
      if (m_popq) m_rpc = m_rd_pc;
      if (dp) begin m_rd_pc = st_pc.pop_back(); m_rd_pr = st_pr.pop_back(); end
      if (acc) begin
        if (st_pc.size() < 9) begin st_pc.push_back(pc); st_pr.push_back(m_run); end
        else m_err = 1;
        m_vec = avec; m_haddr = avec * 4;
      end
      m_ack = acc;
      winner(nxt, req, npn, nv, nvec, npr);
      m_irq = nv && !dp;
      m_run = nxt; m_popq = dp; m_npend = npn; m_nmiq = nmi;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (!rst && !done) begin
    chk("R1 irq", irq, m_irq);
    chk("R2 ack", ack, m_ack);
    chk("R2 vec", vec, m_vec);
    chk("R3 handler_addr", haddr, m_haddr);
    chk("R6 run_level", run, m_run);
    chk("R7 ret_valid", ret_valid, m_rv);
    chk("R4 ret_pc", ret_pc, m_rpc);
    chk("R10 stack_err", stack_err, m_err);
  end

  task automatic take(input logic [15:0] a);
    pc = a; rdy = 1; @(negedge clk); rdy = 0;
  endtask

  task automatic retn();
    ret = 1; @(negedge clk); ret = 0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 irq", irq, 0); chk("R13 ack", ack, 0); chk("R13 run", run, 0);
    chk("R13 ret_valid", ret_valid, 0); chk("R13 err", stack_err, 0);
    rst = 0;
    @(negedge clk);
    // empty return ignored
    retn();
    chk("R11 empty ret", ret_valid, 0); chk("R11 empty run", run, 0);
    // priority 2 device enters
    req[0] = 1; @(negedge clk);
    chk("R1 irq raised", irq, 1);
    take(16'h0100);
    chk("R2 ack", ack, 1); chk("R2 vec", vec, 1); chk("R3 addr", haddr, 4); chk("R2 run", run, 2);
    // priority 5 preempts
    req[2] = 1; @(negedge clk);
    take(16'h0200);
    chk("R6 vec", vec, 3); chk("R3 addr", haddr, 12); chk("R6 run", run, 5);
    // priority 4 is held
    req[1] = 1; @(negedge clk);
    chk("R5 held irq", irq, 0);
    take(16'h0300);
    chk("R5 held ack", ack, 0); chk("R5 held run", run, 5);
    // return from 5: held 4 signalled with the restored frame
    req[2] = 0; retn();
    chk("R7 ret_valid", ret_valid, 1); chk("R4 ret_pc", ret_pc, 16'h0200);
    chk("R7 run", run, 2); chk("R7 irq", irq, 1);
    take(16'h0210);
    chk("R5 taken vec", vec, 2); chk("R5 taken run", run, 4);
    req[1] = 0; retn();
    chk("R4 pc", ret_pc, 16'h0210); chk("R7 run", run, 2); chk("R7 irq low", irq, 0);
    req[0] = 0; retn();
    chk("R4 pc", ret_pc, 16'h0100); chk("R7 run", run, 0);
    // tie between devices 1 and 3
    req[1] = 1; req[3] = 1; @(negedge clk);
    take(16'h0400);
    chk("R9 tie vec", vec, 2);
    req[1] = 0; retn();
    chk("R12 retaken irq", irq, 1);
    take(16'h0410);
    chk("R12 vec", vec, 4);
    req[3] = 0; retn();
    // dropped request is forgotten
    req[0] = 1; @(negedge clk); req[0] = 0; @(negedge clk);
    chk("R12 dropped", irq, 0);
    // ret and ready together
    req[0] = 1; @(negedge clk); take(16'h0500);
    req[2] = 1; @(negedge clk);
    ret = 1; rdy = 1; @(negedge clk); ret = 0; rdy = 0;
    chk("R11 ret wins ack", ack, 0);
    @(negedge clk);
    chk("R11 ret done", ret_valid, 1); chk("R11 run", run, 0);
    take(16'h0510);
    chk("R6 vec", vec, 3); chk("R6 run", run, 5);
    req = '0; retn();
    chk("R7 run", run, 0);
    // nonmaskable over level 5 and over itself
    req[2] = 1; @(negedge clk); take(16'h0600);
    nmi = 1; @(negedge clk); nmi = 0;
    chk("R8 irq", irq, 1);
    take(16'h0610);
    chk("R8 vec", vec, 0); chk("R3 addr", haddr, 0); chk("R8 run", run, 7);
    nmi = 1; @(negedge clk); nmi = 0;
    chk("R8 irq at 7", irq, 1);
    take(16'h0620);
    chk("R8 nested", ack, 1);
    retn(); chk("R8 pc", ret_pc, 16'h0620); chk("R8 run", run, 7);
    retn(); chk("R8 run", run, 5);
    req[2] = 0; retn(); chk("R8 run", run, 0);
    // overflow
    for (int i = 0; i < 10; i++) begin
      nmi = 1; @(negedge clk); nmi = 0;
      take(16'h1000 + 16'(i));
    end
    chk("R10 err", stack_err, 1); chk("R10 run", run, 7);
    for (int i = 0; i < 9; i++) begin
      retn();
      chk("R10 pc order", ret_pc, 16'h1008 - i);
    end
    chk("R10 run", run, 0);
    retn();
    chk("R11 empty ret", ret_valid, 0); chk("R10 sticky", stack_err, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule